// File: doc/BRIEF.md
# EEPROM Image Checksum Engine

This engine proves or repairs the integrity word of a configuration image stored in a word-organised EEPROM. It never talks to the memory directly. It walks the image through a generic word read port and, when repairing, a word write port. Each port uses a request/acknowledge pair with a per-transfer error flag. The serial protocol behind those ports lives elsewhere.

A validate strobe reads every word from address 0 through the checksum slot. The words are added into a 16-bit sum that wraps, and the image is declared good when that sum equals 0xBABA. An update strobe sums only the words below the checksum slot. It then writes 0xBABA minus that sum into the slot, so a later validate passes. Each operation ends with a one-cycle done pulse. A pass flag and an error flag are held alongside it until the next operation starts.

Top module: `eeprom_csum_engine`

## Requirements
- R1: While rst_ni is low, and after its release until a strobe arrives, busy_o, rd_req_o, wr_req_o, done_o, pass_o and err_o are all 0.
- R2: Validate issues reads in ascending address order from 0 through CSUM_ADDR (default 63). Only one read is outstanding at a time. rd_req_o and rd_addr_o hold until rd_ack_i, and the next address appears only in the cycle after the acknowledge.
- R3: The sum is 16 bits wide and wraps modulo 65536. At the end of a validate, done_o rises with err_o=0, and pass_o=1 exactly when the sum equals 0xBABA (otherwise pass_o=0).
- R4: Update reads addresses 0 through CSUM_ADDR-1 only. It then issues exactly one write with wr_addr_o=CSUM_ADDR and wr_data_o = 0xBABA minus the wrapped sum.
- R5: A read acknowledged with rd_err_i=1 ends the operation in the next cycle with done_o=1, err_o=1 and pass_o=0. No further read or write is issued.
- R6: An update whose write is acknowledged with wr_err_i=1 ends with err_o=1 and pass_o=0. A clean write acknowledge ends with pass_o=1 and err_o=0.
- R7: busy_o is 1 from the cycle after an accepted strobe until the cycle in which done_o is 1. Strobes arriving while busy_o is 1 are ignored and do not alter the running operation.
- R8: done_o is a one-cycle pulse in the cycle after the final acknowledge. pass_o and err_o hold their values until the next accepted strobe clears them. If both strobes arrive together while idle, the validate is performed.
- R9: rd_req_o and wr_req_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| validate_i | input | 1 | Start a validate pass |
| update_i | input | 1 | Start a checksum rewrite |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Image good (validate) or write accepted (update) |
| err_o | output | 1 | A read or write transfer failed |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | AW | Word read address |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_data_i | input | 16 | Read data, valid with rd_ack_i |
| rd_err_i | input | 1 | Read failed, valid with rd_ack_i |
| wr_req_o | output | 1 | Word write request |
| wr_addr_o | output | AW | Word write address |
| wr_data_o | output | 16 | Word write data |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write failed, valid with wr_ack_i |

## Verification
Assertions check the transfer protocol on every cycle. They cover mutual exclusion of the two requests, request and address holding until acknowledge, one-step address advance, the fixed write address, immediate termination after a transfer error, the single-cycle done pulse and the exclusivity of pass and error. Only the bench scenarios can show that the wrapped sum and the written checksum value are numerically right. The same holds for a repaired image validating afterwards, the exact count of words read in each mode, a failing read halting the walk, and strobes raised mid-operation leaving the result untouched.

// File: rtl/eeprom_csum_pkg.sv
package eeprom_csum_pkg;
  localparam int          WORD_W      = 16;
  localparam logic [15:0] CSUM_TARGET = 16'hBABA;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } csum_state_e;

  typedef enum logic {
    OP_VALIDATE = 1'b0,
    OP_UPDATE   = 1'b1
  } csum_op_e;
endpackage

// File: rtl/eeprom_csum_addr.sv
module eeprom_csum_addr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [AW-1:0] last_i,
  output logic [AW-1:0] addr_o,
  output logic          at_last_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + AW'(1);
  end

  assign addr_o    = addr_q;
  assign at_last_o = (addr_q == last_i);
endmodule

// File: rtl/eeprom_csum_acc.sv
module eeprom_csum_acc
  import eeprom_csum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] sum_nxt_o
);
  logic [WORD_W-1:0] sum_q;

  // wraps modulo 2^WORD_W by width truncation
  assign sum_nxt_o = sum_q + data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_nxt_o;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/eeprom_csum_fsm.sv
module eeprom_csum_fsm
  import eeprom_csum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              validate_i,
  input  logic              update_i,
  input  logic              rd_ack_i,
  input  logic              rd_err_i,
  input  logic              wr_ack_i,
  input  logic              wr_err_i,
  input  logic              at_last_i,
  input  logic [WORD_W-1:0] sum_nxt_i,
  output logic              clr_o,
  output logic              add_o,
  output logic              inc_o,
  output csum_op_e          op_o,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_o
);
  csum_state_e       state_q;
  csum_op_e          op_q;
  logic              done_q, pass_q, err_q;
  logic [WORD_W-1:0] wdata_q;
  logic              rd_fire;

  assign rd_fire = (state_q == ST_READ) && rd_ack_i;
  assign clr_o   = (state_q == ST_IDLE) && (validate_i || update_i);
  assign add_o   = rd_fire && !rd_err_i;
  assign inc_o   = add_o && !at_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_VALIDATE;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (validate_i || update_i) begin
            state_q <= ST_READ;
            op_q    <= validate_i ? OP_VALIDATE : OP_UPDATE; // validate wins
            pass_q  <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        ST_READ: begin
          if (rd_ack_i) begin
            if (rd_err_i) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
            end else if (at_last_i) begin
              if (op_q == OP_VALIDATE) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                pass_q  <= (sum_nxt_i == CSUM_TARGET);
              end else begin
                state_q <= ST_WRITE;
                wdata_q <= CSUM_TARGET - sum_nxt_i;
              end
            end
          end
        end
        ST_WRITE: begin
          if (wr_ack_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= wr_err_i;
            pass_q  <= !wr_err_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign op_o      = op_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign rd_req_o  = (state_q == ST_READ);
  assign wr_req_o  = (state_q == ST_WRITE);
  assign wr_data_o = wdata_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign err_o     = err_q;
endmodule

// File: rtl/eeprom_csum_engine.sv
module eeprom_csum_engine
  import eeprom_csum_pkg::*;
#(
  parameter int AW        = 6,
  parameter int CSUM_ADDR = 63   // must be >= 1 and < 2**AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          validate_i,
  input  logic          update_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          err_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [15:0]   rd_data_i,
  input  logic          rd_err_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [15:0]   wr_data_o,
  input  logic          wr_ack_i,
  input  logic          wr_err_i
);
  localparam logic [AW-1:0] LAST_VAL = AW'(CSUM_ADDR);
  localparam logic [AW-1:0] LAST_UPD = AW'(CSUM_ADDR - 1);

  logic              clr, add, inc, at_last;
  logic [AW-1:0]     last_addr;
  logic [WORD_W-1:0] sum, sum_nxt;
  csum_op_e          op;

  assign last_addr = (op == OP_UPDATE) ? LAST_UPD : LAST_VAL;

  eeprom_csum_addr #(.AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .inc_i     (inc),
    .last_i    (last_addr),
    .addr_o    (rd_addr_o),
    .at_last_o (at_last)
  );

  eeprom_csum_acc u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .add_i     (add),
    .data_i    (rd_data_i),
    .sum_o     (sum),
    .sum_nxt_o (sum_nxt)
  );

  eeprom_csum_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .validate_i (validate_i),
    .update_i   (update_i),
    .rd_ack_i   (rd_ack_i),
    .rd_err_i   (rd_err_i),
    .wr_ack_i   (wr_ack_i),
    .wr_err_i   (wr_err_i),
    .at_last_i  (at_last),
    .sum_nxt_i  (sum_nxt),
    .clr_o      (clr),
    .add_o      (add),
    .inc_o      (inc),
    .op_o       (op),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .wr_req_o   (wr_req_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .err_o      (err_o)
  );

  assign wr_addr_o = LAST_VAL;

  logic unused_sum;
  assign unused_sum = ^sum;
endmodule

// File: rtl/eeprom_csum_chk.sv
module eeprom_csum_chk #(
  parameter int AW        = 6,
  parameter int CSUM_ADDR = 63
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          err_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          rd_err_i,
  input logic          wr_req_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_ack_i,
  input logic          wr_err_i
);
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o)); // R9

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && !rd_err_i |=> !rd_req_o || (rd_addr_o == $past(rd_addr_o) + AW'(1))); // R2

  AST_RD_ERR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i && rd_err_i |=> done_o && err_o && !pass_o && !rd_req_o && !wr_req_o); // R5

  AST_WR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_addr_o == AW'(CSUM_ADDR)); // R4

  AST_WR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i && wr_err_i |=> done_o && err_o && !pass_o); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rd_ack_i && !wr_ack_i |=> busy_o && $stable(rd_addr_o)); // R7

  AST_PASS_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && err_o)); // R3
endmodule

bind eeprom_csum_engine eeprom_csum_chk #(.AW(AW), .CSUM_ADDR(CSUM_ADDR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .err_o     (err_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ack_i  (rd_ack_i),
  .rd_err_i  (rd_err_i),
  .wr_req_o  (wr_req_o),
  .wr_addr_o (wr_addr_o),
  .wr_ack_i  (wr_ack_i),
  .wr_err_i  (wr_err_i)
);

// File: tb/eeprom_csum_engine_test.sv
`timescale 1ns/1ps
module eeprom_csum_engine_test;
  localparam int AW = 6;
  localparam int CS = 63;
  localparam int NW = 1 << AW;
  localparam int TGT = 16'hBABA;

  logic clk = 0, rst_n = 0;
  logic validate = 0, update = 0;
  logic busy, done, pass, err;
  logic rd_req, rd_ack = 0, rd_err = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [15:0] rd_data = 0, wr_data;
  logic wr_req, wr_ack = 0, wr_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  eeprom_csum_engine #(.AW(AW), .CSUM_ADDR(CS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .validate_i(validate), .update_i(update),
    .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .rd_err_i(rd_err),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ack_i(wr_ack), .wr_err_i(wr_err));

  int total = 0, bad = 0;
  logic [15:0] mem [NW];
  int lat = 0, err_at = -1, wfail = 0;
  int rd_cnt = 0, wr_cnt = 0, last_waddr = -1, last_wdata = -1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory responder, drives inputs away from the active edge
  initial begin
    int rc = 0, wc = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin rd_ack = 0; rd_err = 0; rc = 0; end
      else if (rd_req) begin
        if (rc >= lat) begin
          rd_ack = 1; rd_data = mem[int'(rd_addr)];
          rd_err = (int'(rd_addr) == err_at); rd_cnt++;
        end else rc++;
      end
      if (wr_ack) begin wr_ack = 0; wr_err = 0; wc = 0; end
      else if (wr_req) begin
        if (wc >= lat) begin
          wr_ack = 1; wr_err = (wfail != 0); wr_cnt++;
          last_waddr = int'(wr_addr); last_wdata = int'(wr_data);
          if (wfail == 0) mem[int'(wr_addr)] = wr_data;
        end else wc++;
      end
    end
  end

  // behavioural reference model
  int m_st = 0, m_mode = 0, m_addr = 0, m_sum = 0, m_wdata = 0;
  bit m_done = 0, m_pass = 0, m_err = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mode = 0; m_addr = 0; m_sum = 0; m_wdata = 0;
      m_done = 0; m_pass = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (validate || update) begin
          m_st = 1; m_mode = validate ? 0 : 1; m_addr = 0; m_sum = 0;
          m_pass = 0; m_err = 0;
        end
      end else if (m_st == 1) begin
        if (rd_ack) begin
          if (rd_err) begin m_st = 0; m_done = 1; m_err = 1; end
          else begin
            m_sum = (m_sum + int'(rd_data)) % 65536;
            if (m_addr == (m_mode ? CS - 1 : CS)) begin
              if (m_mode == 0) begin m_st = 0; m_done = 1; m_pass = (m_sum == TGT); end
              else begin m_st = 2; m_wdata = (TGT - m_sum + 65536) % 65536; end
            end else m_addr++;
          end
        end
      end else if (m_st == 2) begin
        if (wr_ack) begin m_st = 0; m_done = 1; m_err = wr_err; m_pass = !wr_err; end
      end
    end
  end

  // per-cycle comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check(busy == (m_st != 0), "R7 busy", busy, m_st != 0);
        check(rd_req == (m_st == 1), "R2 rd_req", rd_req, m_st == 1);
        if (m_st == 1) check(int'(rd_addr) == m_addr, "R2 rd_addr", rd_addr, m_addr);
        check(wr_req == (m_st == 2), "R4 wr_req", wr_req, m_st == 2);
        if (m_st == 2) begin
          check(int'(wr_addr) == CS, "R4 wr_addr", wr_addr, CS);
          check(int'(wr_data) == m_wdata, "R4 wr_data", wr_data, m_wdata);
        end
        check(done == m_done, "R8 done", done, m_done);
        check(pass == m_pass, "R3 pass", pass, m_pass);
        check(err == m_err, "R5 err", err, m_err);
        check(!(rd_req && wr_req), "R9 excl", {rd_req, wr_req}, 0);
      end
    end
  end

  function automatic int sum_to(input int last);
    int s = 0;
    for (int i = 0; i <= last; i++) s = (s + int'(mem[i])) % 65536;
    return s;
  endfunction

  bit r_pass, r_err;
  task automatic run_op(input bit v, input bit u, input int stray_at);
    int n = 0;
    rd_cnt = 0; wr_cnt = 0; last_waddr = -1; last_wdata = -1;
    @(negedge clk); validate = v; update = u;
    @(negedge clk); validate = 0; update = 0;
    while (!done && n < 3000) begin
      if (n == stray_at) begin validate = 1; update = 1; end
      else begin validate = 0; update = 0; end
      @(negedge clk); n++;
    end
    validate = 0; update = 0;
    r_pass = pass; r_err = err;
    @(negedge clk);
    check(!done, "R8 done pulse width", done, 0);
    check(pass == r_pass && err == r_err, "R8 result hold", {pass, err}, {r_pass, r_err});
    check(!busy && !rd_req && !wr_req, "R5 quiet after done", {busy, rd_req, wr_req}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp;
    for (int i = 0; i < NW; i++) mem[i] = 16'(i * 16'h1357 ^ 16'h0A0A);
    mem[CS] = 16'((TGT - sum_to(CS - 1) + 65536) % 65536);
    repeat (3) @(negedge clk);
    check({busy, rd_req, wr_req, done, pass, err} == 0, "R1 reset state", {busy, rd_req, wr_req, done, pass, err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check({busy, rd_req, wr_req, done, pass, err} == 0, "R1 idle after reset", {busy, rd_req, wr_req, done, pass, err}, 0);

    // R3 good image
    lat = 0; run_op(1, 0, -1);
    check(r_pass && !r_err, "R3 good image passes", {r_pass, r_err}, 2'b10);
    check(rd_cnt == CS + 1, "R2 validate read count", rd_cnt, CS + 1);

    // R3 corrupted image
    mem[10] = mem[10] ^ 16'h0001; lat = 2; run_op(1, 0, -1);
    check(!r_pass && !r_err, "R3 bad image fails", {r_pass, r_err}, 0);

    // R4 update repairs checksum
    lat = 1; exp = (TGT - sum_to(CS - 1) + 65536) % 65536;
    run_op(0, 1, -1);
    check(rd_cnt == CS, "R4 update read count", rd_cnt, CS);
    check(wr_cnt == 1 && last_waddr == CS, "R4 write address", last_waddr, CS);
    check(last_wdata == exp, "R4 write data", last_wdata, exp);
    check(r_pass && !r_err, "R6 clean write passes", {r_pass, r_err}, 2'b10);
    lat = 0; run_op(1, 0, -1);
    check(r_pass, "R3 repaired image passes", r_pass, 1);

    // R3 wraparound of the sum
    for (int i = 0; i < CS; i++) mem[i] = 16'hFFFF;
    exp = (TGT - sum_to(CS - 1) + 65536) % 65536;
    lat = 3; run_op(0, 1, -1);
    check(last_wdata == exp, "R3 wrapped checksum", last_wdata, exp);
    lat = 0; run_op(1, 0, -1);
    check(r_pass, "R3 wrapped image passes", r_pass, 1);

    // R5 read error in validate
    err_at = 5; lat = 1; run_op(1, 0, -1);
    check(r_err && !r_pass, "R5 read error flagged", {r_pass, r_err}, 2'b01);
    check(rd_cnt == 6, "R5 reads stop at error", rd_cnt, 6);
    // R5 read error in update: no write
    err_at = CS - 1; run_op(0, 1, -1);
    check(r_err && wr_cnt == 0, "R5 no write after read error", wr_cnt, 0);
    err_at = -1;

    // R6 write error
    wfail = 1; run_op(0, 1, -1);
    check(r_err && !r_pass && wr_cnt == 1, "R6 write error flagged", {r_pass, r_err}, 2'b01);
    wfail = 0;

    // R7 strobes while busy ignored
    lat = 1; run_op(0, 1, 20);
    check(rd_cnt == CS && wr_cnt == 1, "R7 stray strobe ignored", rd_cnt, CS);
    check(r_pass, "R7 result unaffected", r_pass, 1);

    // R8 both strobes: validate wins
    lat = 0; run_op(1, 1, -1);
    check(wr_cnt == 0 && rd_cnt == CS + 1, "R8 validate priority", wr_cnt, 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule